// File: doc/BRIEF.md
# Charger Input Fault Supervisor

This block is the decision core of a switching battery charger. It runs on the system clock and reads a set of already-digitized comparator flags: input over-voltage, input back under the over-voltage hysteresis point, input below its minimum level, input qualified as a usable source, input sitting below battery voltage plus a sleep margin, and a strobe that marks each power-stage pulse. From these flags it decides whether charging may run, whether the input pass switch must be forced open, and whether the charger should sleep to keep the battery from back-feeding the input. It also reports the reason through a 3-bit fault code, a 2-bit status code and a one-shot pulse on a status pin.

An input under-voltage while charging ends the session and starts a retry interval. Charging comes back only once that interval has run out and the input is above its minimum again. An input over-voltage opens the pass switch at once. The fault clears only when the input has dropped through the hysteresis band, and charging then waits for the input to be qualified again. When charging runs but the power stage emits no pulse for a whole starvation window, the block treats this as a battery above its regulation target and flags it. All interval lengths are parameters counted in clock ticks.

Top module: `chg_input_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `chg_en_o`=0, `pass_off_o`=0, `sleep_o`=0, `fault_o`=000, `status_o`=00 and `stat_pulse_o`=0.
- R2: From idle, with `vin_ok_i` high and none of over-voltage, under-voltage or near-battery flagged, charging starts on the next edge: `chg_en_o`=1 and `status_o`=01 (charging). Without `vin_ok_i` the block stays idle.
- R3: When `vin_near_bat_i` is high, `vin_uv_i` is low and `vin_ov_i` is low in idle or while charging, the block sleeps on the next edge: `sleep_o`=1 and `chg_en_o`=0, status 00. `vin_ok_i` has no effect during sleep. Sleep is left to idle once `vin_near_bat_i` drops or `vin_uv_i` rises.
- R4: While charging, `vin_uv_i` high (no over-voltage) stops charging on the next edge with `fault_o`=011 and `status_o`=11.
- R5: After an under-voltage stop, charging resumes no sooner than RETRY_TICKS cycles after the stop, and only on an edge where `vin_uv_i` is low. If the input is still low when the interval ends, the block keeps waiting and resumes on the first edge that sees it recovered. On resumption the fault code returns to 000 and the status to 01.
- R6: In any state, `vin_ov_i` high forces on the next edge `pass_off_o`=1, `chg_en_o`=0, `fault_o`=001 and `status_o`=11.
- R7: The over-voltage fault is held, with the pass switch open, until `vin_ov_clr_i` is seen with `vin_ov_i` low. The fault code then returns to 000, the status to 00 and `pass_off_o` to 0. Charging resumes only on a later edge with `vin_ok_i` high.
- R8: If charging runs for STARVE_TICKS consecutive cycles with `pwm_pulse_i` low, charging stops on the next edge with `fault_o`=100 and `status_o`=11. Any pulse restarts the window.
- R9: In the battery over-voltage state, a `pwm_pulse_i` returns the block to charging with `fault_o`=000 and `status_o`=01.
- R10: Each entry into a fault state (fault 001, 011 or 100, including a change from one fault to another) raises `stat_pulse_o` on the same edge that updates the fault code. The pulse stays high for exactly PULSE_TICKS cycles and fires once for each entry.
- R11: When conditions coincide, over-voltage wins over under-voltage, and under-voltage wins over starvation. Simultaneous over- and under-voltage therefore give fault 001, and under-voltage on the last cycle of a starvation window gives 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vin_ov_i | input | 1 | Input above the over-voltage trip point |
| vin_ov_clr_i | input | 1 | Input back below the over-voltage hysteresis point |
| vin_uv_i | input | 1 | Input below its minimum level |
| vin_ok_i | input | 1 | Input qualified as a valid source |
| vin_near_bat_i | input | 1 | Input below battery voltage plus sleep margin |
| pwm_pulse_i | input | 1 | One strobe per power-stage pulse |
| chg_en_o | output | 1 | Charging allowed |
| pass_off_o | output | 1 | Force the input pass switch open |
| sleep_o | output | 1 | Sleep, reverse current blocked |
| fault_o | output | 3 | Fault code: 000 none, 001 input OV, 011 input UV, 100 battery OV |
| status_o | output | 2 | Status code: 00 ready, 01 charging, 11 fault |
| stat_pulse_o | output | 1 | One-shot status pin pulse |

## Verification
The hardest cases depend on windows measured in clock cycles. One is a retry that must wait out its full interval and then keep waiting because the input is still low. Another is a starvation window that must restart after a single late pulse, or lose to an under-voltage arriving on its very last cycle. The bench uses short timer parameters and counts edges exactly from the entry into each state. It checks the outputs one cycle before and on the cycle the transition is due. It also counts the cycles for which the status pulse is high across a whole fault episode.

// File: rtl/chg_sup_pkg.sv
// Package: shared state type, fault and status encodings and the flag bundle
// used by the charger input supervisor. Assumes nothing beyond IEEE 1800-2017.
package chg_sup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CHARGE   = 3'd1,
        ST_SLEEP    = 3'd2,
        ST_UV_WAIT  = 3'd3,
        ST_OV_HOLD  = 3'd4,
        ST_OV_REVAL = 3'd5,
        ST_BAT_OV   = 3'd6
    } sup_state_e;

    localparam logic [2:0] FLT_NONE   = 3'b000;
    localparam logic [2:0] FLT_IN_OV  = 3'b001;
    localparam logic [2:0] FLT_IN_UV  = 3'b011;
    localparam logic [2:0] FLT_BAT_OV = 3'b100;

    localparam logic [1:0] STS_READY    = 2'b00;
    localparam logic [1:0] STS_CHARGING = 2'b01;
    localparam logic [1:0] STS_FAULT    = 2'b11;

    typedef struct packed {
        logic in_ov;
        logic ov_cleared;
        logic in_uv;
        logic in_valid;
        logic near_bat;
        logic pwm_seen;
    } sup_flags_t;

    // True for the states that report a fault code.
    function automatic logic is_fault_state(sup_state_e s);
        return (s == ST_UV_WAIT) || (s == ST_OV_HOLD) || (s == ST_BAT_OV);
    endfunction

endpackage

// File: rtl/chg_sup_tick_timer.sv
// Module: saturating tick counter. It counts the cycles for which run_i is high
// and reports done_o while running at the last count.
// Assumes: LIMIT >= 1; clr_i has priority over run_i.
module chg_sup_tick_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Count up while running, hold at the last value, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Done while running with the final count reached.
    assign done_o = run_i && (cnt_q == LAST);

    // R5 R8: the count never passes its final value
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8: a clear always restarts the window
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/chg_sup_stat_pulse.sv
// Module: one-shot generator for the status pin. A trigger loads the length
// and the pin stays high until the count runs out. A new trigger restarts it.
// Assumes: PULSE_TICKS >= 1.
module chg_sup_stat_pulse #(
    parameter int unsigned PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int unsigned W = $clog2(PULSE_TICKS + 1);
    localparam logic [W-1:0] LEN = W'(PULSE_TICKS);

    logic [W-1:0] left_q;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trig_i) begin
            left_q <= LEN;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = (left_q != '0);

    // R10
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> pulse_o);

    // R10
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && left_q == W'(1)) |=> !pulse_o);

endmodule

// File: rtl/chg_sup_fsm.sv
// Module: supervisor state machine. It applies the priority over-voltage >
// under-voltage > near-battery > starvation and decodes the outputs from the state.
// Assumes: flags are synchronous to clk, and the timer done signals come from
// counters that are cleared whenever their state is not active.
module chg_sup_fsm
    import chg_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sup_flags_t flags_i,
    input  logic       retry_done_i,
    input  logic       starve_done_i,
    output sup_state_e state_o,
    output logic       fault_entry_o,
    output logic       chg_en_o,
    output logic       pass_off_o,
    output logic       sleep_o,
    output logic [2:0] fault_o,
    output logic [1:0] status_o
);
    sup_state_e state_q, state_d;

    // Next-state selection with fixed fault priority.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flags_i.in_ov)          state_d = ST_OV_HOLD;
                else if (flags_i.in_uv)     state_d = ST_IDLE;
                else if (flags_i.near_bat)  state_d = ST_SLEEP;
                else if (flags_i.in_valid)  state_d = ST_CHARGE;
            end
            ST_CHARGE: begin
                if (flags_i.in_ov)          state_d = ST_OV_HOLD;
                else if (flags_i.in_uv)     state_d = ST_UV_WAIT;
                else if (flags_i.near_bat)  state_d = ST_SLEEP;
                else if (starve_done_i)     state_d = ST_BAT_OV;
            end
            ST_SLEEP: begin
                if (flags_i.in_ov)          state_d = ST_OV_HOLD;
                else if (flags_i.in_uv || !flags_i.near_bat)
                                            state_d = ST_IDLE;
            end
            ST_UV_WAIT: begin
                if (flags_i.in_ov)          state_d = ST_OV_HOLD;
                else if (retry_done_i && !flags_i.in_uv)
                                            state_d = ST_CHARGE;
            end
            ST_OV_HOLD: begin
                if (!flags_i.in_ov && flags_i.ov_cleared)
                                            state_d = ST_OV_REVAL;
            end
            ST_OV_REVAL: begin
                if (flags_i.in_ov)          state_d = ST_OV_HOLD;
                else if (flags_i.in_valid && !flags_i.in_uv && !flags_i.near_bat)
                                            state_d = ST_CHARGE;
            end
            ST_BAT_OV: begin
                if (flags_i.in_ov)          state_d = ST_OV_HOLD;
                else if (flags_i.pwm_seen)  state_d = ST_CHARGE;
            end
            default:                        state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Flag the edge that enters a fault state from any other state.
    assign fault_entry_o = rst_n && is_fault_state(state_d) && (state_d != state_q);

    // Moore decode of the control, fault and status outputs.
    always_comb begin
        chg_en_o   = 1'b0;
        pass_off_o = 1'b0;
        sleep_o    = 1'b0;
        fault_o    = FLT_NONE;
        status_o   = STS_READY;
        unique case (state_q)
            ST_CHARGE: begin
                chg_en_o = 1'b1;
                status_o = STS_CHARGING;
            end
            ST_SLEEP:   sleep_o = 1'b1;
            ST_UV_WAIT: begin
                fault_o  = FLT_IN_UV;
                status_o = STS_FAULT;
            end
            ST_OV_HOLD: begin
                pass_off_o = 1'b1;
                fault_o    = FLT_IN_OV;
                status_o   = STS_FAULT;
            end
            ST_BAT_OV: begin
                fault_o  = FLT_BAT_OV;
                status_o = STS_FAULT;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R6 R11
    ov_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_i.in_ov |=> (fault_o == FLT_IN_OV && pass_off_o && !chg_en_o));

    // R4
    uv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && !flags_i.in_ov && flags_i.in_uv)
        |=> (fault_o == FLT_IN_UV && status_o == STS_FAULT && !chg_en_o));

    // R5
    retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UV_WAIT && !retry_done_i) |=> !chg_en_o);

    // R7
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OV_HOLD && !flags_i.ov_cleared) |=> pass_off_o);

    // R8
    starve_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && starve_done_i && !flags_i.in_ov &&
         !flags_i.in_uv && !flags_i.near_bat) |=> (fault_o == FLT_BAT_OV));

    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_CHARGE) && flags_i.near_bat &&
         !flags_i.in_uv && !flags_i.in_ov) |=> (sleep_o && !chg_en_o));

endmodule

// File: rtl/chg_input_supervisor.sv
// Module: top of the charger input supervisor. It bundles the comparator flags,
// runs the retry and starvation timers beside the state machine and drives the
// status pin one-shot.
// Assumes: all inputs are already synchronized to clk. Timer lengths are in clock ticks.
module chg_input_supervisor
    import chg_sup_pkg::*;
#(
    parameter int unsigned RETRY_TICKS  = 250_000_000,
    parameter int unsigned STARVE_TICKS = 3_750_000,
    parameter int unsigned PULSE_TICKS  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vin_ov_i,
    input  logic       vin_ov_clr_i,
    input  logic       vin_uv_i,
    input  logic       vin_ok_i,
    input  logic       vin_near_bat_i,
    input  logic       pwm_pulse_i,
    output logic       chg_en_o,
    output logic       pass_off_o,
    output logic       sleep_o,
    output logic [2:0] fault_o,
    output logic [1:0] status_o,
    output logic       stat_pulse_o
);
    sup_flags_t flags;
    sup_state_e state;
    logic       retry_done, starve_done, fault_entry;
    logic       in_uv_wait, in_charge;

    // Gather the comparator flags into one bundle.
    always_comb begin
        flags.in_ov      = vin_ov_i;
        flags.ov_cleared = vin_ov_clr_i;
        flags.in_uv      = vin_uv_i;
        flags.in_valid   = vin_ok_i;
        flags.near_bat   = vin_near_bat_i;
        flags.pwm_seen   = pwm_pulse_i;
    end

    assign in_uv_wait = (state == ST_UV_WAIT);
    assign in_charge  = (state == ST_CHARGE);

    chg_sup_tick_timer #(.LIMIT(RETRY_TICKS)) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!in_uv_wait),
        .run_i  (in_uv_wait),
        .done_o (retry_done)
    );

    chg_sup_tick_timer #(.LIMIT(STARVE_TICKS)) u_starve (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!in_charge || pwm_pulse_i),
        .run_i  (in_charge && !pwm_pulse_i),
        .done_o (starve_done)
    );

    chg_sup_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .flags_i       (flags),
        .retry_done_i  (retry_done),
        .starve_done_i (starve_done),
        .state_o       (state),
        .fault_entry_o (fault_entry),
        .chg_en_o      (chg_en_o),
        .pass_off_o    (pass_off_o),
        .sleep_o       (sleep_o),
        .fault_o       (fault_o),
        .status_o      (status_o)
    );

    chg_sup_stat_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (fault_entry),
        .pulse_o (stat_pulse_o)
    );

    // R10: the pin rises together with a changed, non-zero fault code
    pin_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_pulse_o) |-> (fault_o != FLT_NONE && status_o == STS_FAULT));

endmodule

// File: tb/chg_input_supervisor_tb.sv
`timescale 1ns/1ps
module chg_input_supervisor_tb;
    localparam int RETRY  = 20;
    localparam int STARVE = 16;
    localparam int PULSE  = 4;
    localparam int NVEC   = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov = 0, ovc = 0, uv = 0, vld = 0, slp = 0, pwm = 0;
    logic chg_en, pass_off, sleep_s, stat_pulse;
    logic [2:0] fault;
    logic [1:0] status;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    chg_input_supervisor #(.RETRY_TICKS(RETRY), .STARVE_TICKS(STARVE),
                           .PULSE_TICKS(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .vin_ov_i(ov), .vin_ov_clr_i(ovc),
        .vin_uv_i(uv), .vin_ok_i(vld), .vin_near_bat_i(slp), .pwm_pulse_i(pwm),
        .chg_en_o(chg_en), .pass_off_o(pass_off), .sleep_o(sleep_s),
        .fault_o(fault), .status_o(status), .stat_pulse_o(stat_pulse));

    // inputs {ov,ovc,uv,vld,slp,pwm} ; expected {chg,poff,sleep,fault[3],status[2],pulse}
    localparam logic [14:0] VEC [NVEC] = '{
        {6'b000100, 9'b1_0_0_000_01_0},  // R2 start
        {6'b000101, 9'b1_0_0_000_01_0},  // R2 keep charging
        {6'b000110, 9'b0_0_1_000_00_0},  // R3 sleep entry
        {6'b000010, 9'b0_0_1_000_00_0},  // R3 stay asleep
        {6'b000100, 9'b0_0_0_000_00_0},  // R3 leave to idle, ok ignored
        {6'b000101, 9'b1_0_0_000_01_0},  // R2 restart
        {6'b100000, 9'b0_1_0_001_11_1},  // R6 OV trip, R10 pulse
        {6'b100000, 9'b0_1_0_001_11_1},  // R6 hold
        {6'b000000, 9'b0_1_0_001_11_1},  // R7 held without clear
        {6'b010000, 9'b0_0_0_000_00_1},  // R7 cleared, R10 4th cycle
        {6'b000000, 9'b0_0_0_000_00_0},  // R7 no charge without ok
        {6'b000101, 9'b1_0_0_000_01_0},  // R7 revalidated
        {6'b101000, 9'b0_1_0_001_11_1},  // R11 OV over UV
        {6'b010000, 9'b0_0_0_000_00_1},  // R7
        {6'b000101, 9'b1_0_0_000_01_1},  // R7 R10
        {6'b000101, 9'b1_0_0_000_01_1},  // R10 last pulse cycle
        {6'b000101, 9'b1_0_0_000_01_0}   // R10 pulse over
    };

    function automatic logic [8:0] outs();
        return {chg_en, pass_off, sleep_s, fault, status, stat_pulse};
    endfunction

    task automatic chk(input string req, input logic [8:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic drive(input logic [5:0] v);
        {ov, ovc, uv, vld, slp, pwm} = v;
    endtask

    task automatic do_reset();
        drive(6'b0);
        rst_n = 1'b0;
        step(); step();
        chk("R1 reset state", 9'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pulses;
        step();
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][14:9]);
            step();
            checks++;
            if (outs() !== VEC[i][8:0]) begin
                errors++;
                $display("FAIL vector %0d (R2 R3 R6 R7 R10 R11): got %b expected %b",
                         i, outs(), VEC[i][8:0]);
            end
        end

        // R5 R10: UV held past the retry interval, then recovers
        do_reset();
        drive(6'b000101); step();
        chk("R2 charging before UV", 9'b1_0_0_000_01_0);
        drive(6'b001101); step();
        chk("R4 UV stop", 9'b0_0_0_011_11_1);
        pulses = 1;
        for (int k = 0; k < RETRY + 2; k++) begin
            step();
            if (stat_pulse) pulses++;
            chk_bit("R5 still waiting with UV", chg_en, 1'b0);
        end
        chk_bit("R10 pulse count", (pulses == PULSE), 1'b1);
        drive(6'b000101); step();
        chk("R5 resume after recovery", 9'b1_0_0_000_01_0);

        // R5: UV clears at once, resume exactly after the interval
        drive(6'b001101); step();
        chk("R4 second UV stop", 9'b0_0_0_011_11_1);
        drive(6'b000101);
        for (int k = 0; k < RETRY - 1; k++) step();
        chk_bit("R5 no early resume", chg_en, 1'b0);
        step();
        chk("R5 resume at interval end", 9'b1_0_0_000_01_0);

        // R8: starvation window, restarted once by a late pulse
        drive(6'b000100);
        for (int k = 0; k < 10; k++) step();
        drive(6'b000101); step();
        drive(6'b000100);
        for (int k = 0; k < STARVE - 1; k++) step();
        chk("R8 still charging before window end", 9'b1_0_0_000_01_0);
        step();
        chk("R8 battery OV trip", 9'b0_0_0_100_11_1);
        drive(6'b000101); step();
        chk("R9 pulse returns to charging", 9'b1_0_0_000_01_1);

        // R11: UV on the last starvation cycle wins
        drive(6'b000101); step();
        drive(6'b000100);
        for (int k = 0; k < STARVE - 1; k++) step();
        drive(6'b001100); step();
        chk("R11 UV over starvation", 9'b0_0_0_011_11_1);

        // R1: reset in the middle of a fault
        drive(6'b100000); step();
        rst_n = 1'b0; step();
        chk("R1 reset from fault", 9'b0);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule